// File: doc/BRIEF.md
# Accumulator ALU with Four-Flag Status

This block is the combinational arithmetic and logic core of a small accumulator machine. Each cycle the surrounding datapath presents the accumulator, a second byte, the current four-bit flag state and an operation code. The block returns the new byte, a strobe that says whether that byte should be written back, and the next flag state. Where the operands come from, how instructions are decoded and how many cycles they take are all outside this block.

The flag state carries four bits: zero, subtract, half-carry and carry. The subtract and half-carry bits exist so that a following decimal-adjust step can repair a packed BCD sum or difference. Compare runs the subtract path for its flags only. Two further operations set or toggle the carry flag and leave the byte alone.

A helper output packs the incoming flag state into a byte in the layout used when the flags are saved to the stack.

Top module: `acc_alu`

## Requirements
- R1: Flag nibble layout, on both `flags_i` and `flags_o`: bit 3 is Z, bit 2 is N, bit 1 is H, bit 0 is C. The op codes are: 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare, 8 complement, 9 decimal adjust, 10 set carry, 11 complement carry, and 12 to 15 reserved. Add (op 0) and add-with-carry (op 1) return the low 8 bits of `acc_i + opnd_i`, plus the incoming C for op 1. They set C on a carry out of bit 7, set H on a carry out of bit 3, clear N, and assert `wr_en_o`.
- R2: Subtract (op 2) and subtract-with-borrow (op 3) return the low 8 bits of `acc_i - opnd_i`, minus the incoming C for op 3. They set C on a borrow out of bit 7, set H on a borrow from bit 4 into bit 3, set N, and assert `wr_en_o`.
- R3: Compare (op 7) produces the same Z, N, H and C as op 2 with the same operands, and keeps `wr_en_o` low.
- R4: For ops 0 to 7 and op 9, Z is set exactly when the 8-bit result is zero.
- R5: AND (op 4) sets H and clears N and C. XOR (op 5) and OR (op 6) clear N, H and C. All three assert `wr_en_o`.
- R6: Complement (op 8) returns `~acc_i` with `wr_en_o` high. It sets N and H and passes Z and C through unchanged.
- R7: Decimal adjust (op 9) with incoming N clear adds 0x06 when H is set or the low nibble is above 9. It adds 0x60 when C is set or the accumulator is above 0x99, and in that case sets C; otherwise C is cleared. The result is written.
- R8: Decimal adjust with incoming N set subtracts 0x06 when H is set and 0x60 when C is set, and C keeps its incoming value. In both directions H is cleared and N is left as it came in.
- R9: Set carry (op 10) forces C to 1 and complement carry (op 11) inverts C. Both clear N and H, keep Z, hold `result_o` equal to `acc_i`, and keep `wr_en_o` low.
- R10: `flag_byte_o` carries `flags_i` as Z at bit 7, N at bit 6, H at bit 5 and C at bit 4, with bits 3 to 0 always zero.
- R11: Reserved op codes 12 to 15 keep `wr_en_o` low, return `acc_i` on `result_o` and pass `flags_i` through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 4 | Current flags {Z,N,H,C} |
| op_i | input | 4 | Operation select |
| result_o | output | 8 | Computed byte |
| wr_en_o | output | 1 | Write result back to the accumulator |
| flags_o | output | 4 | Next flags {Z,N,H,C} |
| flag_byte_o | output | 8 | `flags_i` packed for a stack transfer |

## Verification
The checker assumes that every input is driven to known values whenever it samples the block. It treats all sixteen op codes as legal, including the four reserved ones, and it makes no assumption that the flag nibble is consistent with the accumulator. The stimulus therefore draws all four inputs over their full ranges. This includes flag combinations that no real instruction sequence would produce, such as N set together with a large accumulator before a decimal adjust. Directed vectors add the BCD carry and borrow cases and the zero-result and wrap-around boundaries.

// File: rtl/acc_alu.sv
module acc_alu (
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic [3:0] flags_i,
  input  logic [3:0] op_i,
  output logic [7:0] result_o,
  output logic       wr_en_o,
  output logic [3:0] flags_o,
  output logic [7:0] flag_byte_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CP  = 4'd7;
  localparam logic [3:0] OP_CPL = 4'd8, OP_DAA = 4'd9, OP_SCF = 4'd10, OP_CCF = 4'd11;

  logic z_in, n_in, h_in, c_in;
  assign {z_in, n_in, h_in, c_in} = flags_i;

  logic cy;
  assign cy = (op_i == OP_ADC || op_i == OP_SBC) ? c_in : 1'b0;

  logic [4:0] add_lo, sub_lo;
  logic [8:0] add_w, sub_w;
  assign add_lo = {1'b0, acc_i[3:0]} + {1'b0, opnd_i[3:0]} + {4'd0, cy};
  assign add_w  = {1'b0, acc_i} + {1'b0, opnd_i} + {8'd0, cy};
  assign sub_lo = {1'b0, acc_i[3:0]} - {1'b0, opnd_i[3:0]} - {4'd0, cy};
  assign sub_w  = {1'b0, acc_i} - {1'b0, opnd_i} - {8'd0, cy};

  logic fix_lo, fix_hi;
  logic [7:0] fix, daa_res;
  assign fix_lo  = h_in | (~n_in & (acc_i[3:0] > 4'd9));
  assign fix_hi  = c_in | (~n_in & (acc_i > 8'h99));
  assign fix     = {1'b0, fix_hi, fix_hi, 1'b0, 1'b0, fix_lo, fix_lo, 1'b0};
  assign daa_res = n_in ? acc_i - fix : acc_i + fix;

  assign flag_byte_o = {flags_i, 4'b0000};

  always_comb begin
    result_o = acc_i;
    wr_en_o  = 1'b0;
    flags_o  = flags_i;
    unique case (op_i)
      OP_ADD, OP_ADC: begin
        result_o = add_w[7:0];
        wr_en_o  = 1'b1;
        flags_o  = {add_w[7:0] == 8'd0, 1'b0, add_lo[4], add_w[8]};
      end
      OP_SUB, OP_SBC: begin
        result_o = sub_w[7:0];
        wr_en_o  = 1'b1;
        flags_o  = {sub_w[7:0] == 8'd0, 1'b1, sub_lo[4], sub_w[8]};
      end
      OP_CP: begin
        result_o = sub_w[7:0];
        flags_o  = {sub_w[7:0] == 8'd0, 1'b1, sub_lo[4], sub_w[8]};
      end
      OP_AND: begin
        result_o = acc_i & opnd_i;
        wr_en_o  = 1'b1;
        flags_o  = {(acc_i & opnd_i) == 8'd0, 3'b010};
      end
      OP_XOR: begin
        result_o = acc_i ^ opnd_i;
        wr_en_o  = 1'b1;
        flags_o  = {(acc_i ^ opnd_i) == 8'd0, 3'b000};
      end
      OP_OR: begin
        result_o = acc_i | opnd_i;
        wr_en_o  = 1'b1;
        flags_o  = {(acc_i | opnd_i) == 8'd0, 3'b000};
      end
      OP_CPL: begin
        result_o = ~acc_i;
        wr_en_o  = 1'b1;
        flags_o  = {z_in, 1'b1, 1'b1, c_in};
      end
      OP_DAA: begin
        result_o = daa_res;
        wr_en_o  = 1'b1;
        flags_o  = {daa_res == 8'd0, n_in, 1'b0, fix_hi};
      end
      OP_SCF: flags_o = {z_in, 2'b00, 1'b1};
      OP_CCF: flags_o = {z_in, 2'b00, ~c_in};
      default: ;
    endcase
  end
endmodule

module acc_alu_chk (
  input logic [7:0] acc_i,
  input logic [7:0] opnd_i,
  input logic [3:0] flags_i,
  input logic [3:0] op_i,
  input logic [7:0] result_o,
  input logic       wr_en_o,
  input logic [3:0] flags_o,
  input logic [7:0] flag_byte_o
);
  logic known;
  assign known = !$isunknown({acc_i, opnd_i, flags_i, op_i});

  always_comb begin
    if (known) begin
      p_cmp_nowrite_r3: assert (!(op_i == 4'd7) || !wr_en_o)
        else $error("compare wrote its result");
      p_zero_flag_r4: assert (!(op_i <= 4'd7 || op_i == 4'd9) || (flags_o[3] == (result_o == 8'd0)))
        else $error("Z disagrees with result");
      p_logic_flags_r5: assert (!(op_i >= 4'd4 && op_i <= 4'd6) ||
                               (flags_o[2:0] == ((op_i == 4'd4) ? 3'b010 : 3'b000)))
        else $error("logic op flags wrong");
      p_cpl_invert_r6: assert (!(op_i == 4'd8) || (result_o == ~acc_i && wr_en_o))
        else $error("complement result wrong");
      p_carry_ops_r9: assert (!(op_i == 4'd10 || op_i == 4'd11) ||
                              (!wr_en_o && flags_o[3] == flags_i[3] && flags_o[2:1] == 2'b00 &&
                               flags_o[0] == ((op_i == 4'd10) ? 1'b1 : ~flags_i[0])))
        else $error("carry op wrong");
      p_pack_layout_r10: assert (flag_byte_o[3:0] == 4'd0 && flag_byte_o[7:4] == flags_i)
        else $error("flag byte layout wrong");
      p_reserved_r11: assert (!(op_i >= 4'd12) || (!wr_en_o && flags_o == flags_i && result_o == acc_i))
        else $error("reserved op had an effect");
    end
  end
endmodule

bind acc_alu acc_alu_chk u_acc_alu_chk (.*);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [7:0] acc, opnd, res, fbyte;
  logic [3:0] flg, op, fout;
  logic wr;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  acc_alu u_acc_alu (.acc_i(acc), .opnd_i(opnd), .flags_i(flg), .op_i(op),
                     .result_o(res), .wr_en_o(wr), .flags_o(fout), .flag_byte_o(fbyte));

  function automatic logic [12:0] model(logic [3:0] o, logic [7:0] a, logic [7:0] b, logic [3:0] f);
    int x, lo, adj;
    logic [7:0] r;
    logic z, n, h, c, w;
    r = a; w = 0; {z, n, h, c} = f;
    case (o)
      0, 1: begin
        x = int'(a) + int'(b) + ((o == 1) ? int'(f[0]) : 0);
        lo = int'(a % 16) + int'(b % 16) + ((o == 1) ? int'(f[0]) : 0);
        r = x[7:0]; w = 1; n = 0; h = lo > 15; c = x > 255;
      end
      2, 3, 7: begin
        x = int'(a) - int'(b) - ((o == 3) ? int'(f[0]) : 0);
        lo = int'(a % 16) - int'(b % 16) - ((o == 3) ? int'(f[0]) : 0);
        r = x[7:0]; w = (o != 7); n = 1; h = lo < 0; c = x < 0;
      end
      4: begin r = a & b; w = 1; n = 0; h = 1; c = 0; end
      5: begin r = a ^ b; w = 1; n = 0; h = 0; c = 0; end
      6: begin r = a | b; w = 1; n = 0; h = 0; c = 0; end
      8: begin r = ~a; w = 1; n = 1; h = 1; end
      9: begin
        adj = 0;
        if (!f[2]) begin
          if (f[1] || (a % 16) > 9) adj += 6;
          if (f[0] || a > 8'h99) begin adj += 96; c = 1; end else c = 0;
          x = int'(a) + adj;
        end else begin
          if (f[1]) adj += 6;
          if (f[0]) adj += 96;
          x = int'(a) - adj;
        end
        r = x[7:0]; w = 1; h = 0;
      end
      10: begin n = 0; h = 0; c = 1; end
      11: begin n = 0; h = 0; c = ~f[0]; end
      default: ;
    endcase
    if (o <= 7 || o == 9) z = (r == 0);
    return {w, z, n, h, c, r};
  endfunction

  function automatic string tag(logic [3:0] o);
    case (o)
      0, 1: return "R1";
      2, 3: return "R2";
      7: return "R3";
      4, 5, 6: return "R5";
      8: return "R6";
      9: return "R7/R8";
      10, 11: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(logic [3:0] o, logic [7:0] a, logic [7:0] b, logic [3:0] f, string t);
    logic [12:0] exp;
    @(negedge clk);
    op = o; acc = a; opnd = b; flg = f;
    #(CLK_PERIOD/4);
    exp = model(o, a, b, f);
    checks++;
    if ({wr, fout, res} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h f=%b: got wr=%b f=%b r=%h expected wr=%b f=%b r=%h",
               t, o, a, b, f, wr, fout, res, exp[12], exp[11:8], exp[7:0]);
    end
    checks++;
    if (fbyte !== {f, 4'b0000}) begin
      errors++;
      $display("FAIL R10 flag byte got %h expected %h", fbyte, {f, 4'b0000});
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'h5eed_1234);
    acc = 0; opnd = 0; flg = 0; op = 0;
    apply(4'd0, 8'h00, 8'h00, 4'b0000, "R4 zero add");
    apply(4'd0, 8'hFF, 8'h01, 4'b0000, "R1 wrap");
    apply(4'd0, 8'h0F, 8'h01, 4'b0000, "R1 half carry");
    apply(4'd1, 8'hFE, 8'h01, 4'b0001, "R1 adc carry in");
    apply(4'd2, 8'h10, 8'h01, 4'b0000, "R2 half borrow");
    apply(4'd2, 8'h00, 8'h01, 4'b0000, "R2 borrow");
    apply(4'd3, 8'h01, 8'h00, 4'b0001, "R2 sbc to zero");
    apply(4'd7, 8'h42, 8'h42, 4'b0000, "R3 equal compare");
    apply(4'd7, 8'h10, 8'h20, 4'b1111, "R3 less compare");
    apply(4'd4, 8'hF0, 8'h0F, 4'b0001, "R5 and zero");
    apply(4'd5, 8'hAA, 8'hAA, 4'b0111, "R5 xor zero");
    apply(4'd6, 8'h80, 8'h01, 4'b0111, "R5 or");
    apply(4'd8, 8'h5A, 8'h00, 4'b1001, "R6 complement");
    apply(4'd9, 8'h3C, 8'h00, 4'b0000, "R7 low fix");
    apply(4'd9, 8'h9A, 8'h00, 4'b0000, "R7 both fix to zero");
    apply(4'd9, 8'h00, 8'h00, 4'b0011, "R7 flags driven");
    apply(4'd9, 8'h2D, 8'h00, 4'b0110, "R8 half borrow");
    apply(4'd9, 8'hF3, 8'h00, 4'b0101, "R8 carry");
    apply(4'd10, 8'h33, 8'h44, 4'b1110, "R9 set carry");
    apply(4'd11, 8'h33, 8'h44, 4'b0111, "R9 toggle carry");
    apply(4'd12, 8'h77, 8'h11, 4'b1010, "R11 reserved");
    apply(4'd15, 8'h00, 8'hFF, 4'b0101, "R11 reserved");
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] o;
      o = 4'($urandom);
      apply(o, 8'($urandom), 8'($urandom), 4'($urandom), tag(o));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule